// File: doc/BRIEF.md
# Slow Converter Handshake Sequencer

This block sits between a fast processor bus and a slow parallel analog-to-digital converter. The converter needs write and read strobes that are many bus cycles wide. A single-cycle bus write to the start address launches a sequence that runs without further help from the processor:

1. A stretched active-low write strobe begins the conversion.
2. The block waits for the converter's active-low done line to fall.
3. It issues a stretched active-low read strobe.
4. At the end of that strobe it captures the converter's output word into a holding register.

The processor reads the holding register or a status word at any later time, with no wait states. A conversion takes up to about 120 µs from the start write to valid data, and software must allow for that. A timeout returns the sequencer to idle if the done line never falls.

Strobe widths are counted in system clocks. Each width is derived from the clock period and rounded up, so that no strobe is shorter than its minimum width in nanoseconds. The done line is asynchronous to the bus clock, so it passes through a synchronizer before the block acts on it.

The data path is a plain register read rather than a valid/ready stream. The converter cannot be stalled, and the processor polls the valid bit, so there is no back-pressure path.

Top module: `adc_handshake_seq`

## Requirements
- R1: After reset, `adc_wr_n` and `adc_rd_n` are high, the sequencer is idle, and `bus_rdata` reads zero at both address 0 and address 1.
- R2: When `bus_wr_en` is high for one clock with `bus_addr` = 0 while idle, `adc_wr_n` goes low from the following clock. It stays low for exactly WR_CYC = ceil(WR_MIN_NS*1000/CLK_PERIOD_PS) cycles, which is 44 cycles (220 ns) at the default 5 ns period. The written data is ignored.
- R3: After the write strobe ends, a falling edge on `adc_done_n` starts the read phase. `adc_done_n` passes through two synchronizer flops, so `adc_rd_n` goes low after the third rising clock edge at which `adc_done_n` is sampled low following a high sample. Falls of `adc_done_n` that occur while the write strobe is low are ignored.
- R4: `adc_rd_n` stays low for exactly RD_CYC cycles (44 at the defaults), and never overlaps `adc_wr_n` low.
- R5: The holding register captures `adc_data` at the clock edge that returns `adc_rd_n` high. It is presented on `bus_rdata` combinationally whenever `bus_addr` = 0.
- R6: With `bus_addr` = 1, `bus_rdata` returns the status word: bit 0 is valid, bit 1 is busy, bit 2 is timeout error, and the upper bits are zero. Valid and error clear at the edge that accepts a start and valid sets at the capture edge. Busy is high from the edge that accepts a start until the sequencer returns to idle.
- R7: A start write that arrives while busy is ignored: the running sequence and its strobe timing are unchanged. A write with `bus_addr` = 1 never starts a sequence.
- R8: If no done fall arrives within TO_CYC = ceil(TIMEOUT_NS*1000/CLK_PERIOD_PS) cycles after the write strobe ends (30000 cycles, 150 µs, at the defaults), the sequencer returns to idle and sets the error bit. Valid stays clear and the holding register keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr_en | input | 1 | Single-cycle bus write strobe |
| bus_addr | input | 1 | Register select: 0 = start / holding data, 1 = status |
| bus_rdata | output | DATA_W | Combinational read data for the selected register |
| adc_wr_n | output | 1 | Stretched active-low conversion start strobe to the converter |
| adc_rd_n | output | 1 | Stretched active-low read strobe to the converter |
| adc_done_n | input | 1 | Asynchronous active-low conversion-done line from the converter |
| adc_data | input | DATA_W | Converter parallel output word |

## Verification
Timing is counted from the clock edge that samples a stimulus:

- The write strobe falls one edge after an accepted start.
- The read strobe falls three edges after the first low sample of the done line.
- Each strobe rises exactly WR_CYC or RD_CYC edges after it fell.
- Data and the valid bit appear together with the rise of the read strobe.
- The error bit appears TO_CYC edges after the write strobe ends.

A behavioural model in the bench tracks these delays as counters and a history of done samples. After every rising edge it predicts both strobes and the read word, and the bench compares them at the following falling edge, once all registers have settled. A separate converter model measures each strobe's low time independently of that model.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_WR   = 2'd1,
    PH_WAIT = 2'd2,
    PH_RD   = 2'd3
  } seq_phase_t;

  // Minimum number of clocks covering a duration given in ns, rounded up.
  function automatic int ns_to_cycles(input int dur_ns, input int period_ps);
    longint num;
    num = longint'(dur_ns) * 1000 + longint'(period_ps) - 1;
    return int'(num / longint'(period_ps));
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/adc_sync_fall.sv
module adc_sync_fall #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din_n,
  output logic fall
);

  logic [STAGES-1:0] chain_q;
  logic              last_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= din_n;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= {chain_q[STAGES-2:0], din_n};
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_q <= 1'b1;
    else        last_q <= chain_q[STAGES-1];
  end

  assign fall = last_q & ~chain_q[STAGES-1];

endmodule

// File: rtl/adc_down_counter.sv
module adc_down_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         dec,
  output logic         zero
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  cnt_q <= '0;
    else if (load)               cnt_q <= load_val;
    else if (dec && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign zero = (cnt_q == '0);

endmodule

// File: rtl/adc_handshake_seq.sv
module adc_handshake_seq
  import adc_seq_pkg::*;
#(
  parameter int CLK_PERIOD_PS = 5000,
  parameter int WR_MIN_NS     = 220,
  parameter int RD_MIN_NS     = 220,
  parameter int TIMEOUT_NS    = 150000,
  parameter int DATA_W        = 8,
  parameter int SYNC_STAGES   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr_en,
  input  logic              bus_addr,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              adc_wr_n,
  output logic              adc_rd_n,
  input  logic              adc_done_n,
  input  logic [DATA_W-1:0] adc_data
);

  localparam int WR_CYC  = ns_to_cycles(WR_MIN_NS, CLK_PERIOD_PS);
  localparam int RD_CYC  = ns_to_cycles(RD_MIN_NS, CLK_PERIOD_PS);
  localparam int TO_CYC  = ns_to_cycles(TIMEOUT_NS, CLK_PERIOD_PS);
  localparam int STB_MAX = max2(WR_CYC, RD_CYC);
  localparam int STB_W   = $clog2(STB_MAX + 1);
  localparam int TO_W    = $clog2(TO_CYC + 1);
  localparam int STAT_W  = 3;

  seq_phase_t phase_q, phase_d;

  logic              done_fall;
  logic              stb_zero, to_zero;
  logic              stb_load, to_load;
  logic [STB_W-1:0]  stb_val;
  logic              start_req, capture, timeout_hit;
  logic              busy;
  logic              wr_n_q, rd_n_q;
  logic              valid_q, err_q;
  logic [DATA_W-1:0] hold_q;

  // Done line synchronizer and falling-edge detector
  adc_sync_fall #(.STAGES(SYNC_STAGES)) u_done_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .din_n (adc_done_n),
    .fall  (done_fall)
  );

  // One counter times both strobes; they never overlap
  adc_down_counter #(.W(STB_W)) u_stb_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (stb_load),
    .load_val (stb_val),
    .dec      ((phase_q == PH_WR) || (phase_q == PH_RD)),
    .zero     (stb_zero)
  );

  // Watchdog on the conversion wait
  adc_down_counter #(.W(TO_W)) u_to_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (to_load),
    .load_val (TO_W'(TO_CYC - 1)),
    .dec      (phase_q == PH_WAIT),
    .zero     (to_zero)
  );

  assign busy        = (phase_q != PH_IDLE);
  assign start_req   = bus_wr_en && !bus_addr && !busy;
  assign capture     = (phase_q == PH_RD) && stb_zero;
  assign timeout_hit = (phase_q == PH_WAIT) && !done_fall && to_zero;
  assign stb_load    = start_req || ((phase_q == PH_WAIT) && done_fall);
  assign stb_val     = start_req ? STB_W'(WR_CYC - 1) : STB_W'(RD_CYC - 1);
  assign to_load     = (phase_q == PH_WR) && stb_zero;

  always_comb begin
    phase_d = phase_q;
    unique case (phase_q)
      PH_IDLE: if (start_req) phase_d = PH_WR;
      PH_WR:   if (stb_zero)  phase_d = PH_WAIT;
      PH_WAIT: begin
        if (done_fall)    phase_d = PH_RD;
        else if (to_zero) phase_d = PH_IDLE;
      end
      PH_RD:   if (stb_zero)  phase_d = PH_IDLE;
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      wr_n_q  <= 1'b1;
      rd_n_q  <= 1'b1;
    end else begin
      phase_q <= phase_d;
      wr_n_q  <= (phase_d != PH_WR);
      rd_n_q  <= (phase_d != PH_RD);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q  <= '0;
      valid_q <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      if (start_req) begin
        valid_q <= 1'b0;
        err_q   <= 1'b0;
      end
      if (capture) begin
        hold_q  <= adc_data;
        valid_q <= 1'b1;
      end
      if (timeout_hit) err_q <= 1'b1;
    end
  end

  assign adc_wr_n  = wr_n_q;
  assign adc_rd_n  = rd_n_q;
  assign bus_rdata = bus_addr ? {{(DATA_W-STAT_W){1'b0}}, err_q, busy, valid_q}
                              : hold_q;

endmodule

// File: rtl/adc_seq_checker.sv
module adc_seq_checker #(
  parameter int DATA_W = 8,
  parameter int WR_CYC = 44,
  parameter int RD_CYC = 44
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr_en,
  input logic              bus_addr,
  input logic              adc_wr_n,
  input logic              adc_rd_n,
  input logic [DATA_W-1:0] adc_data,
  input logic              busy,
  input logic              valid_q,
  input logic              err_q,
  input logic [DATA_W-1:0] hold_q
);

  logic [31:0] wr_lo_q, rd_lo_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_lo_q <= '0;
      rd_lo_q <= '0;
    end else begin
      wr_lo_q <= adc_wr_n ? 32'd0 : wr_lo_q + 32'd1;
      rd_lo_q <= adc_rd_n ? 32'd0 : rd_lo_q + 32'd1;
    end
  end

  a_r2_start_drops_wr: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && bus_wr_en && !bus_addr) |=> (!adc_wr_n && busy && !valid_q && !err_q));

  a_r2_wr_width: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(adc_wr_n) |-> (wr_lo_q == 32'(WR_CYC)));

  a_r4_rd_width: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(adc_rd_n) |-> (rd_lo_q == 32'(RD_CYC)));

  a_r4_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    (adc_wr_n || adc_rd_n));

  a_r5_capture: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(adc_rd_n) |-> (valid_q && hold_q == $past(adc_data)));

  a_r6_busy_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (!adc_wr_n || !adc_rd_n) |-> busy);

  a_r7_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && adc_wr_n) |=> adc_wr_n);

  a_r8_err_idle: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_q) |-> (!busy && !valid_q && $stable(hold_q)));

endmodule

bind adc_handshake_seq adc_seq_checker #(
  .DATA_W (DATA_W),
  .WR_CYC (WR_CYC),
  .RD_CYC (RD_CYC)
) u_seq_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_wr_en (bus_wr_en),
  .bus_addr  (bus_addr),
  .adc_wr_n  (adc_wr_n),
  .adc_rd_n  (adc_rd_n),
  .adc_data  (adc_data),
  .busy      (busy),
  .valid_q   (valid_q),
  .err_q     (err_q),
  .hold_q    (hold_q)
);

// File: tb/adc_handshake_seq_tb_top.sv
`timescale 1ns/1ps
module adc_handshake_seq_tb_top;

  localparam int PER_PS = 5000;
  localparam int WR_CYC = (220 * 1000 + PER_PS - 1) / PER_PS;
  localparam int RD_CYC = (220 * 1000 + PER_PS - 1) / PER_PS;
  localparam int TO_CYC = (150000 * 1000 + PER_PS - 1) / PER_PS;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_wr_en = 1'b0;
  logic       bus_addr = 1'b0;
  logic [7:0] bus_rdata;
  logic       adc_wr_n, adc_rd_n;
  logic       adc_done_n = 1'b1;
  logic [7:0] adc_data = 8'h00;

  int n_checks = 0;
  int n_fail   = 0;

  always #2.5 clk = ~clk;

  adc_handshake_seq dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_wr_en  (bus_wr_en),
    .bus_addr   (bus_addr),
    .bus_rdata  (bus_rdata),
    .adc_wr_n   (adc_wr_n),
    .adc_rd_n   (adc_rd_n),
    .adc_done_n (adc_done_n),
    .adc_data   (adc_data)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int   m_ph = 0;        // 0 idle, 1 write strobe, 2 waiting, 3 read strobe
  int   m_cnt = 0;
  int   m_tcnt = 0;
  bit   m_valid = 0, m_err = 0, m_ready = 0, m_fall = 0;
  logic [7:0] m_hold = 8'h00;
  int   dh[$];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ph = 0; m_valid = 0; m_err = 0; m_hold = 8'h00; m_ready = 1;
      dh = {1, 1, 1};
    end else begin
      m_fall = (dh[0] == 1) && (dh[1] == 0);
      case (m_ph)
        0: if (bus_wr_en && !bus_addr) begin
             m_ph = 1; m_cnt = WR_CYC; m_valid = 0; m_err = 0;
           end
        1: begin
             m_cnt--;
             if (m_cnt == 0) begin m_ph = 2; m_tcnt = TO_CYC; end
           end
        2: if (m_fall) begin
             m_ph = 3; m_cnt = RD_CYC;
           end else begin
             m_tcnt--;
             if (m_tcnt == 0) begin m_ph = 0; m_err = 1; end
           end
        default: begin
             m_cnt--;
             if (m_cnt == 0) begin m_hold = adc_data; m_valid = 1; m_ph = 0; end
           end
      endcase
      dh.push_back(int'(adc_done_n));
      void'(dh.pop_front());
    end
  end

  // Per-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (m_ready) begin
      check("R2 adc_wr_n", int'(adc_wr_n), (m_ph == 1) ? 0 : 1);
      check("R4 adc_rd_n", int'(adc_rd_n), (m_ph == 3) ? 0 : 1);
      if (bus_addr)
        check("R6 status", int'(bus_rdata),
              int'({5'b0, m_err, (m_ph != 0), m_valid}));
      else
        check("R5 hold", int'(bus_rdata), int'(m_hold));
    end
  end

  // ---------------- converter model ----------------
  int conv_mode = 1;     // 0 never done, 1 normal, 2 spurious done during write
  int conv_dly  = 300;
  int conv_cnt  = -1;
  int wr_lo = 0, rd_lo = 0;

  always @(negedge clk) begin
    if (!rst_n) begin
      adc_done_n = 1'b1; conv_cnt = -1; wr_lo = 0; rd_lo = 0;
    end else begin
      if (!adc_wr_n) begin
        wr_lo++;
        conv_cnt = -1;
        adc_done_n = (conv_mode == 2 && wr_lo >= 5 && wr_lo < 9) ? 1'b0 : 1'b1;
      end else begin
        if (wr_lo != 0) begin
          check("R2 write strobe width", wr_lo, WR_CYC);
          wr_lo = 0;
          if (conv_mode != 0) conv_cnt = conv_dly;
        end
        if (!adc_rd_n) begin
          rd_lo++;
          adc_done_n = 1'b1;
        end else begin
          if (rd_lo != 0) check("R4 read strobe width", rd_lo, RD_CYC);
          rd_lo = 0;
        end
        if (conv_cnt > 0) conv_cnt--;
        else if (conv_cnt == 0) begin adc_done_n = 1'b0; conv_cnt = -1; end
      end
    end
  end

  // ---------------- stimulus ----------------
  task automatic drive(input logic we, input logic addr);
    @(negedge clk);
    #1;
    bus_wr_en = we;
    bus_addr  = addr;
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) drive(1'b0, ~bus_addr);
  endtask

  task automatic start_conv();
    drive(1'b1, 1'b0);
    drive(1'b0, 1'b1);
  endtask

  task automatic wait_idle(input int limit);
    for (int i = 0; i < limit; i++) begin
      drive(1'b0, ~bus_addr);
      if (m_ph == 0) break;
    end
  endtask

  task automatic read_expect(input logic addr, input int exp, input string tag);
    drive(1'b0, addr);
    @(negedge clk);
    check(tag, int'(bus_rdata), exp);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    // R1: reset state at both addresses
    check("R1 adc_wr_n reset", int'(adc_wr_n), 1);
    check("R1 adc_rd_n reset", int'(adc_rd_n), 1);
    check("R1 hold reset", int'(bus_rdata), 0);
    #1 bus_addr = 1'b1;
    @(negedge clk);
    check("R1 status reset", int'(bus_rdata), 0);
    #1 rst_n = 1'b1;
    run(4);

    // R2 R3 R5 R6: normal conversion
    adc_data = 8'hA5; conv_mode = 1; conv_dly = 300;
    start_conv();
    wait_idle(2000);
    read_expect(1'b0, 8'hA5, "R5 captured data");
    read_expect(1'b1, 8'h01, "R6 status valid");

    // R7: write to status address does not start
    drive(1'b1, 1'b1);
    drive(1'b0, 1'b1);
    @(negedge clk);
    check("R7 no start from addr 1", int'(adc_wr_n), 1);
    read_expect(1'b1, 8'h01, "R7 status unchanged");

    // R7: extra starts during write strobe and during wait
    adc_data = 8'h5A; conv_dly = 200;
    start_conv();
    run(10);
    drive(1'b1, 1'b0);
    run(60);
    drive(1'b1, 1'b0);
    wait_idle(2000);
    read_expect(1'b0, 8'h5A, "R7 single capture");

    // R3: spurious done fall during write strobe ignored
    adc_data = 8'h3C; conv_mode = 2; conv_dly = 150;
    start_conv();
    run(30);
    check("R3 still writing", int'(adc_rd_n), 1);
    wait_idle(2000);
    read_expect(1'b0, 8'h3C, "R3 data after real done");

    // R3: done falls immediately after the write strobe
    adc_data = 8'h81; conv_mode = 1; conv_dly = 0;
    start_conv();
    wait_idle(2000);
    read_expect(1'b0, 8'h81, "R3 immediate done");

    // R8: converter never finishes
    adc_data = 8'h77; conv_mode = 0;
    start_conv();
    wait_idle(TO_CYC + 200);
    read_expect(1'b1, 8'h04, "R8 timeout error");
    read_expect(1'b0, 8'h81, "R8 hold kept");

    // R6 R8: next start clears error, full-scale value
    adc_data = 8'hFF; conv_mode = 1; conv_dly = 400;
    start_conv();
    read_expect(1'b1, 8'h02, "R6 busy after start");
    wait_idle(2000);
    read_expect(1'b1, 8'h01, "R8 error cleared");
    read_expect(1'b0, 8'hFF, "R5 full-scale");

    run(5);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule